// File: doc/BRIEF.md
# Scanline Window Wait Unit

This block stalls a display command stream until the scanout position reaches, or leaves, a chosen band of scanlines. It accepts one 64-bit wait instruction through a valid/ready handshake. The instruction carries an opcode that selects the sense of the wait and two packed scanline bounds. The unit then compares the current hardware scanline, supplied each cycle by the display timing generator, against the band. It raises `done_o` for one cycle in the first cycle the condition holds.

A band whose upper bound is below its lower bound wraps through line 0. The unit rewrites such a band internally as the complementary band with the sense inverted, so the comparison is always against an ordered pair. It rejects malformed instructions with a one-cycle error pulse and does not start a wait for them. Malformed means an unknown opcode, a bound beyond the frame, or a band that covers every line of the frame. With a band like that, an inside wait would never stall and an outside wait would never end.

A separate combinational path converts a logical scanline number into the hardware counter domain. It uses the frame height and a line offset, so that software-side numbers can be translated before they are packed. A pending wait can be cancelled by `abort_i`. Back-pressure is simple: `ins_ready_o` is high exactly when no wait is pending, and an instruction transfers on a cycle where both valid and ready are high.

Top module: `scanwin_wait`

## Requirements
- R1: Instruction fields: bits 63:56 are the opcode (0x05 = wait while outside, finish when inside the band; 0x06 = finish when outside the band). Bits 19:0 hold the lower bound and bits 39:20 the upper bound. Bits 55:40 are ignored.
- R2: An instruction transfers when `ins_valid_i` and `ins_ready_o` are both high. `ins_ready_o` is high after reset and whenever no wait is pending. While it is low, a presented instruction is ignored.
- R3: For opcode 0x05 with lower <= upper, `done_o` is high in the first cycle where `cur_line_i` is in [lower, upper]. The earliest such cycle is the one right after the transfer.
- R4: For opcode 0x06 with lower <= upper, `done_o` is high in the first cycle where `cur_line_i` < lower or `cur_line_i` > upper. An outside wait on [0,0] therefore holds for as long as the line input reads 0.
- R5: When upper < lower, the band wraps. Opcode 0x05 finishes when `cur_line_i` >= lower or `cur_line_i` <= upper. Opcode 0x06 finishes when `cur_line_i` lies in [upper+1, lower-1].
- R6: An instruction is illegal if any of these holds: its opcode is neither 0x05 nor 0x06; a bound is >= `vtotal_i`; or it covers the whole frame (lower = 0 with upper = vtotal-1, or upper + 1 = lower). An illegal instruction makes `err_o` high for exactly the one cycle after the transfer, starts no wait, and leaves `ins_ready_o` high.
- R7: `done_o` is a single-cycle pulse, and `ins_ready_o` is high in the cycle after it.
- R8: `abort_i` high while a wait is pending ends the wait without `done_o`, even in a cycle where the condition holds. `ins_ready_o` is high in the next cycle. `abort_i` has no effect while idle.
- R9: `hw_line_o` = (`log_line_i` + `vtotal_i` - `line_offset_i`) mod `vtotal_i` in the same cycle, for inputs below `vtotal_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid_i | input | 1 | Wait instruction offered |
| ins_ready_o | output | 1 | Unit can take an instruction (no wait pending) |
| ins_data_i | input | 64 | Packed wait instruction |
| abort_i | input | 1 | Cancel the pending wait |
| cur_line_i | input | LINE_W | Current hardware scanline |
| vtotal_i | input | LINE_W | Lines per frame |
| line_offset_i | input | LINE_W | Offset between logical and hardware line numbers |
| log_line_i | input | LINE_W | Logical scanline to convert |
| hw_line_o | output | LINE_W | Converted hardware scanline |
| done_o | output | 1 | Wait condition met (one-cycle pulse) |
| err_o | output | 1 | Rejected instruction (one-cycle pulse) |

## Verification
The bench builds the unit with `LINE_W` = 8 and drives a 20-line frame. The line input advances one line per cycle, so every wait resolves within a frame or two of cycles. This makes every band position reachable, including the last line, wrapped bands, and bands that touch line 0. It also makes the whole-frame illegal cases cheap to build. The narrow width leaves the fixed 20-bit instruction fields much wider than the line counter, which exposes the out-of-range bound check.

// File: rtl/scanwin_pkg.sv
`timescale 1ns/1ps
package scanwin_pkg;
  localparam int INS_W   = 64;
  localparam int FIELD_W = 20;
  localparam int LO_LSB  = 0;
  localparam int HI_LSB  = 20;
  localparam int OP_LSB  = 56;
  localparam int OP_W    = 8;

  localparam logic [OP_W-1:0] OP_WAIT_IN  = 8'h05;
  localparam logic [OP_W-1:0] OP_WAIT_OUT = 8'h06;

  typedef enum logic [0:0] {ST_IDLE, ST_WAIT} scanwin_st_e;
endpackage

// File: rtl/scanwin_unpack.sv
`timescale 1ns/1ps
module scanwin_unpack #(
  parameter int LINE_W = 13
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic [scanwin_pkg::INS_W-1:0]      ins_i,
  input  logic [LINE_W-1:0]                  vtotal_i,
  output logic                               bad_o,
  output logic [LINE_W-1:0]                  lo_o,
  output logic [LINE_W-1:0]                  hi_o,
  output logic                               inside_o
);
  import scanwin_pkg::*;

  localparam int EXT_W = FIELD_W + 1;

  logic [OP_W-1:0]    op;
  logic [FIELD_W-1:0] lo_f, hi_f;
  logic [EXT_W-1:0]   vt_x;
  logic [LINE_W-1:0]  lo_n, hi_n;
  logic               op_ok, range_ok, wrap, full;
  logic               unused_rsv;

  assign op         = ins_i[OP_LSB +: OP_W];
  assign lo_f       = ins_i[LO_LSB +: FIELD_W];
  assign hi_f       = ins_i[HI_LSB +: FIELD_W];
  assign unused_rsv = ^ins_i[OP_LSB-1:HI_LSB+FIELD_W];
  assign vt_x       = {{(EXT_W-LINE_W){1'b0}}, vtotal_i};

  always_comb begin
    op_ok    = (op == OP_WAIT_IN) || (op == OP_WAIT_OUT);
    range_ok = ({1'b0, lo_f} < vt_x) && ({1'b0, hi_f} < vt_x);
    lo_n     = lo_f[LINE_W-1:0];
    hi_n     = hi_f[LINE_W-1:0];
    wrap     = hi_n < lo_n;
    if (wrap)
      full = (hi_n + LINE_W'(1)) == lo_n;
    else
      full = (lo_n == '0) && (hi_n == vtotal_i - LINE_W'(1));
    bad_o    = !op_ok || !range_ok || full;
    // A wrapping band becomes its ordered complement with the sense flipped
    lo_o     = wrap ? hi_n + LINE_W'(1) : lo_n;
    hi_o     = wrap ? lo_n - LINE_W'(1) : hi_n;
    inside_o = (op == OP_WAIT_IN) ^ wrap;
  end

  // R5: a legal request always yields an ordered band after conversion
  assert_band_ordered_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bad_o |-> (lo_o <= hi_o));
endmodule

// File: rtl/scanwin_remap.sv
`timescale 1ns/1ps
module scanwin_remap #(
  parameter int LINE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LINE_W-1:0] log_line_i,
  input  logic [LINE_W-1:0] vtotal_i,
  input  logic [LINE_W-1:0] offset_i,
  output logic [LINE_W-1:0] hw_line_o
);
  localparam int SUM_W = LINE_W + 2;

  logic [SUM_W-1:0] sum, red, vt_e;
  logic             unused_top;

  always_comb begin
    vt_e = {2'b00, vtotal_i};
    sum  = {2'b00, log_line_i} + vt_e - {2'b00, offset_i};
    red  = sum - vt_e;
    hw_line_o = (sum >= vt_e) ? red[LINE_W-1:0] : sum[LINE_W-1:0];
  end
  assign unused_top = ^{sum[SUM_W-1:LINE_W], red[SUM_W-1:LINE_W]};

  // R9: in-range inputs always map inside the frame
  assert_remap_in_frame_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((log_line_i < vtotal_i) && (offset_i < vtotal_i)) |-> (hw_line_o < vtotal_i));
endmodule

// File: rtl/scanwin_match.sv
`timescale 1ns/1ps
module scanwin_match #(
  parameter int LINE_W = 13
) (
  input  logic [LINE_W-1:0] line_i,
  input  logic [LINE_W-1:0] lo_i,
  input  logic [LINE_W-1:0] hi_i,
  input  logic              inside_i,
  output logic              hit_o
);
  logic in_band;
  always_comb begin
    in_band = (line_i >= lo_i) && (line_i <= hi_i);
    hit_o   = inside_i ? in_band : !in_band;
  end
endmodule

// File: rtl/scanwin_wait.sv
`timescale 1ns/1ps
module scanwin_wait #(
  parameter int LINE_W = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid_i,
  output logic              ins_ready_o,
  input  logic [63:0]       ins_data_i,
  input  logic              abort_i,
  input  logic [LINE_W-1:0] cur_line_i,
  input  logic [LINE_W-1:0] vtotal_i,
  input  logic [LINE_W-1:0] line_offset_i,
  input  logic [LINE_W-1:0] log_line_i,
  output logic [LINE_W-1:0] hw_line_o,
  output logic              done_o,
  output logic              err_o
);
  import scanwin_pkg::*;

  scanwin_st_e       state;
  logic [LINE_W-1:0] win_lo, win_hi;
  logic              win_inside;
  logic              err_q;
  logic              dec_bad, dec_inside, hit, take;
  logic [LINE_W-1:0] dec_lo, dec_hi;

  scanwin_unpack #(.LINE_W(LINE_W)) u_unpack (
    .clk(clk), .rst_n(rst_n), .ins_i(ins_data_i), .vtotal_i(vtotal_i),
    .bad_o(dec_bad), .lo_o(dec_lo), .hi_o(dec_hi), .inside_o(dec_inside));

  scanwin_match #(.LINE_W(LINE_W)) u_match (
    .line_i(cur_line_i), .lo_i(win_lo), .hi_i(win_hi),
    .inside_i(win_inside), .hit_o(hit));

  scanwin_remap #(.LINE_W(LINE_W)) u_remap (
    .clk(clk), .rst_n(rst_n), .log_line_i(log_line_i), .vtotal_i(vtotal_i),
    .offset_i(line_offset_i), .hw_line_o(hw_line_o));

  assign ins_ready_o = (state == ST_IDLE);
  assign take        = ins_valid_i && ins_ready_o;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      win_lo     <= '0;
      win_hi     <= '0;
      win_inside <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      err_q <= 1'b0;
      unique case (state)
        ST_IDLE: if (take) begin
          if (dec_bad) begin
            err_q <= 1'b1;
          end else begin
            state      <= ST_WAIT;
            win_lo     <= dec_lo;
            win_hi     <= dec_hi;
            win_inside <= dec_inside;
          end
        end
        ST_WAIT: if (abort_i || hit) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign done_o = (state == ST_WAIT) && hit && !abort_i;
  assign err_o  = err_q;

  // R2: a legal transfer makes the unit busy
  assert_take_starts_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !dec_bad) |=> !ins_ready_o);
  // R6: error only follows a transfer and starts no wait
  assert_err_follows_take_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(take));
  assert_err_keeps_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> ins_ready_o);
  // R7: done is a pulse and frees the unit
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> (!done_o && ins_ready_o));
  // R8: abort on a pending wait returns to idle
  assert_abort_frees_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ins_ready_o && abort_i) |=> ins_ready_o);
endmodule

// File: tb/scanwin_wait_tb.sv
`timescale 1ns/1ps
module scanwin_wait_tb_top;
  localparam int LW = 8;
  localparam int VT = 20;
  localparam int NV = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          ins_valid;
  logic          ins_ready;
  logic [63:0]   ins_data;
  logic          abort;
  logic [LW-1:0] cur_line, vtotal, offs, log_line, hw_line;
  logic          done, err;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  scanwin_wait #(.LINE_W(LW)) dut_i (
    .clk(clk), .rst_n(rst_n), .ins_valid_i(ins_valid), .ins_ready_o(ins_ready),
    .ins_data_i(ins_data), .abort_i(abort), .cur_line_i(cur_line),
    .vtotal_i(vtotal), .line_offset_i(offs), .log_line_i(log_line),
    .hw_line_o(hw_line), .done_o(done), .err_o(err));

  // op, lower, upper, start line, reserved-bit filler
  localparam int VEC [NV][5] = '{
    '{5,  5,  9,  0, 0},       // R3 inside, reached later
    '{5,  5,  9,  7, 0},       // R3 inside, met at once
    '{6,  5,  9,  6, 0},       // R4 outside
    '{6,  3,  3,  3, 0},       // R4 single-line band
    '{5, 17,  2,  5, 0},       // R5 wrapping inside
    '{5, 17,  2,  1, 0},       // R5 wrapping inside, immediate
    '{6, 17,  2, 18, 0},       // R5 wrapping outside
    '{5, 19, 19,  0, 0},       // R3 last line of frame
    '{5,  0,  4, 10, 16'hA5C3},// R1 reserved bits ignored
    '{6, 10, 19, 12, 0}        // R4 band touching frame end
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [63:0] pack(input int op, input int lo, input int hi, input int rsv);
    logic [63:0] w;
    w = '0;
    w[63:56] = op[7:0];
    w[55:40] = rsv[15:0];
    w[39:20] = hi[19:0];
    w[19:0]  = lo[19:0];
    return w;
  endfunction

  // Expected cycle (1 = first cycle after transfer) from R3/R4/R5
  function automatic int model_k(input int op, input int lo, input int hi, input int s);
    for (int k = 1; k <= 2*VT; k++) begin
      int  x;
      bit  inb, h;
      x   = (s + k - 1) % VT;
      inb = (hi < lo) ? (x >= lo || x <= hi) : (x >= lo && x <= hi);
      h   = (op == 5) ? inb : !inb;
      if (h) return k;
    end
    return 0;
  endfunction

  task automatic send(input logic [63:0] w);
    @(negedge clk);
    ins_valid = 1'b1;
    ins_data  = w;
  endtask

  task automatic run_wait(input int op, input int lo, input int hi, input int s,
                          input int rsv, input string req);
    int got;
    got = 0;
    send(pack(op, lo, hi, rsv));
    @(negedge clk);
    ins_valid = 1'b0;
    cur_line  = LW'(s);
    #1;
    for (int i = 1; i <= 2*VT + 2; i++) begin
      if (done) begin got = i; break; end
      @(negedge clk);
      cur_line = LW'((int'(cur_line) + 1) % VT);
      #1;
    end
    check(got == model_k(op, lo, hi, s), req, got, model_k(op, lo, hi, s));
    @(negedge clk);
    #1;
    check(ins_ready && !done, "R7", {ins_ready, done}, 2);
  endtask

  task automatic expect_reject(input logic [63:0] w, input string req);
    send(w);
    @(negedge clk);
    ins_valid = 1'b0;
    #1;
    check(err && ins_ready && !done, req, {err, ins_ready, done}, 6);
    @(negedge clk);
    #1;
    check(!err && ins_ready, req, {err, ins_ready}, 1);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ins_valid = 1'b0; ins_data = '0; abort = 1'b0;
    cur_line = '0; vtotal = LW'(VT); offs = '0; log_line = '0;
    repeat (3) @(negedge clk);
    #1;
    check(ins_ready && !done && !err, "R2", {ins_ready, done, err}, 4);
    rst_n = 1'b1;
    @(negedge clk);
    #1;
    check(ins_ready && !done && !err, "R7", {ins_ready, done, err}, 4);

    for (int v = 0; v < NV; v++)
      run_wait(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], $sformatf("vec%0d", v));

    // R4: outside [0,0] holds while the line reads 0 (display asleep)
    begin
      bit seen;
      seen = 1'b0;
      send(pack(6, 0, 0, 0));
      @(negedge clk);
      ins_valid = 1'b0;
      cur_line  = '0;
      for (int i = 0; i < 8; i++) begin
        #1;
        if (done) seen = 1'b1;
        @(negedge clk);
      end
      check(!seen && !ins_ready, "R4 sleep hold", seen, 0);
      cur_line = LW'(1);
      #1;
      check(done, "R4 resume", done, 1);
      @(negedge clk);
    end

    // R6: illegal instructions
    expect_reject(pack(7, 2, 4, 0), "R6 opcode");
    expect_reject(pack(5, 20, 25, 0), "R6 range");
    expect_reject(pack(6, 3, 400, 0), "R6 range upper");
    expect_reject(pack(5, 0, 19, 0), "R6 full frame");
    expect_reject(pack(6, 5, 4, 0), "R6 full wrap");

    // R2: instruction offered while busy is ignored
    send(pack(5, 10, 12, 0));
    @(negedge clk);
    cur_line  = '0;
    ins_data  = pack(5, 0, 0, 0);
    #1;
    check(!done && !ins_ready, "R2 busy ignore", done, 0);
    @(negedge clk);
    ins_valid = 1'b0;
    cur_line  = LW'(11);
    #1;
    check(done, "R2 first kept", done, 1);
    @(negedge clk);

    // R8: abort during a hit suppresses done
    send(pack(5, 10, 12, 0));
    @(negedge clk);
    ins_valid = 1'b0;
    cur_line  = LW'(3);
    @(negedge clk);
    cur_line = LW'(10);
    abort    = 1'b1;
    #1;
    check(!done, "R8 abort masks done", done, 0);
    @(negedge clk);
    abort = 1'b0;
    #1;
    check(ins_ready && !done, "R8 abort frees", {ins_ready, done}, 2);

    // R8: abort while idle has no effect
    abort = 1'b1;
    @(negedge clk);
    #1;
    check(ins_ready && !done && !err, "R8 idle abort", {ins_ready, done, err}, 4);
    abort = 1'b0;
    run_wait(5, 2, 2, 0, 0, "R8 after idle abort");

    // R9: logical to hardware line remap
    begin
      int rv [5][3] = '{'{0,3,17}, '{5,3,2}, '{19,0,19}, '{18,19,19}, '{3,3,0}};
      for (int i = 0; i < 5; i++) begin
        @(negedge clk);
        log_line = LW'(rv[i][0]);
        offs     = LW'(rv[i][1]);
        #1;
        check(int'(hw_line) == rv[i][2], "R9 remap", int'(hw_line), rv[i][2]);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule